// File: doc/BRIEF.md
# OUT Packet Commit/Skip Gate

This block sits between a packet receiver and an output FIFO that external logic drains. Received OUT packets are stored in a small pool of packet buffers. Each buffer moves from free, to filling, to held or draining, and then back to free. In automatic mode a packet is queued for the consumer as soon as its last byte is stored. In manual mode every completed packet waits for firmware to decide its fate.

Firmware releases the oldest held packet by writing the low byte-count register. Bit 7 of the written value is the skip flag. When it is clear, the packet is queued for the consumer with the length recorded at reception. When it is set, the packet is dropped, its buffer goes straight back to the free pool, and the consumer side never sees it. The register port uses three addresses: 0 is the configuration register, whose bit 4 enables automatic forwarding; 1 is the high byte-count register, which is ignored; 2 is the low byte-count register, which performs the re-arm.

The consumer reads bytes through a valid/ready port, and `out_last` marks the final byte of each packet. `pkt_held` and per-buffer occupancy counts let firmware see that a decision is pending.

Top module: `ogate_commit_gate`

## Requirements
- R1: After reset, `rx_ready` is 1, `out_valid` is 0, `pkt_held` is 0, every occupancy count is 0, and automatic forwarding is on.
- R2: With automatic forwarding on, each completed packet appears at the output port with its bytes in order and `out_last` on its final byte, and `pkt_held` stays 0. Several packets come out in the order they were received.
- R3: With automatic forwarding off (address 0, bit 4 = 0), a completed packet raises `pkt_held`, keeps `out_valid` at 0, and shows its byte count in the occupancy of its buffer.
- R4: A write to address 2 with bit 7 = 0 while a packet is held commits that packet to the output port with its received length, whatever bits 6:0 hold. Writes to address 1 change nothing.
- R5: A write to address 2 with bit 7 = 1 while a packet is held drops that packet. From the next cycle its buffer's occupancy is 0, and none of its bytes ever reach the output port.
- R6: A write to address 2 while no packet is held has no effect: no output, no change in `pkt_held`, and no change in occupancy.
- R7: When several packets are held, each re-arm write applies to the oldest one, and committed packets leave in the order they were received.
- R8: `rx_ready` is 0 while no buffer is free and no packet is being filled, and it returns to 1 once a buffer has been freed.
- R9: Changing the forwarding bit while a packet is held does not release that packet. Packets completed after automatic forwarding is switched on are forwarded directly.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold steady.
- R11: A packet that reaches the buffer capacity (512 bytes by default) without `rx_last` is closed at that byte, and `out_last` marks that byte on output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receiver byte valid |
| rx_data | input | DW | Receiver byte |
| rx_last | input | 1 | Final byte of the packet |
| rx_ready | output | 1 | A byte can be accepted |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 count high, 2 count low) |
| reg_wdata | input | 8 | Register write data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DW | Output byte |
| out_last | output | 1 | Final byte of the output packet |
| out_ready | input | 1 | Consumer accepts the byte |
| pkt_held | output | 1 | At least one packet awaits a firmware decision |
| occ_flat | output | NBUF*LENW | Byte count of each buffer, buffer 0 in the low field |

## Verification
Some properties are checked on every cycle. A held buffer stays held unless it is at the head of the decision queue on a re-arm. A commit keeps the recorded length. A skip frees the buffer one cycle later. A manual-mode completion raises the held flag. A stalled output stays stable. No ordering queue is ever popped while it is empty. Other behaviour only shows up at the ports over whole scenarios, and the bench scenarios cover it: byte order and packet order, a dropped packet never surfacing, back-pressure when both buffers are occupied, the mode toggle with a held packet, and closing a packet at full capacity.

// File: rtl/ogate_pkg.sv
package ogate_pkg;

    typedef enum logic [1:0] {
        B_FREE  = 2'd0,
        B_FILL  = 2'd1,
        B_HELD  = 2'd2,
        B_DRAIN = 2'd3
    } buf_state_e;

    localparam logic [1:0] REG_CFG = 2'd0;
    localparam logic [1:0] REG_BCH = 2'd1;
    localparam logic [1:0] REG_BCL = 2'd2;

    localparam int CFG_AUTO_BIT = 4;
    localparam int BCL_SKIP_BIT = 7;

endpackage

// File: rtl/ogate_idxq.sv
module ogate_idxq #(
    parameter int DEPTH = 2,
    parameter int W     = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push0,
    input  logic [W-1:0] din0,
    input  logic         push1,
    input  logic [W-1:0] din1,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH*W-1:0] q, nq;
    logic [CW-1:0]      cnt, ncnt;

    always_comb begin
        nq   = q;
        ncnt = cnt;
        if (pop) begin
            nq   = q >> W;
            ncnt = ncnt - CW'(1);
        end
        if (push0 && ncnt < CW'(DEPTH)) begin
            nq[int'(ncnt)*W +: W] = din0;
            ncnt = ncnt + CW'(1);
        end
        if (push1 && ncnt < CW'(DEPTH)) begin
            nq[int'(ncnt)*W +: W] = din1;
            ncnt = ncnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            cnt <= '0;
        end else begin
            q   <= nq;
            cnt <= ncnt;
        end
    end

    assign head     = q[W-1:0];
    assign nonempty = (cnt != '0);

    // R6: a decision or drain never pops an empty queue
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt != '0);

    // R7: the ordering queue never receives more entries than it can keep
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push0 && push1 && !pop) |-> cnt <= CW'(DEPTH - 2));

endmodule

// File: rtl/ogate_store.sv
module ogate_store #(
    parameter int NBUF  = 2,
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    parameter int IDXW  = 1,
    parameter int POSW  = 9
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] wbuf,
    input  logic [POSW-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [IDXW-1:0] rbuf,
    input  logic [POSW-1:0] raddr,
    output logic [DW-1:0]   rdata
);
    localparam int MAW = $clog2(NBUF * DEPTH);

    logic [DW-1:0]  mem [NBUF*DEPTH];
    logic [MAW-1:0] wa, ra;

    assign wa = MAW'(wbuf) * MAW'(DEPTH) + MAW'(waddr);
    assign ra = MAW'(rbuf) * MAW'(DEPTH) + MAW'(raddr);

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wdata;
    end

    assign rdata = mem[ra];

endmodule

// File: rtl/ogate_commit_gate.sv
module ogate_commit_gate
    import ogate_pkg::*;
#(
    parameter int NBUF  = 2,
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int LENW = $clog2(DEPTH + 1),
    localparam int POSW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_valid,
    input  logic [DW-1:0]        rx_data,
    input  logic                 rx_last,
    output logic                 rx_ready,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic                 out_valid,
    output logic [DW-1:0]        out_data,
    output logic                 out_last,
    input  logic                 out_ready,
    output logic                 pkt_held,
    output logic [NBUF*LENW-1:0] occ_flat
);
    buf_state_e      st  [NBUF];
    logic [LENW-1:0] len [NBUF];

    logic            auto_q;
    logic            fill_active;
    logic [IDXW-1:0] fill_buf, first_free, wr_buf;
    logic            any_free;
    logic            rx_fire, pkt_end;
    logic [LENW-1:0] wr_len;

    logic            rearm, skip, commit, drop;
    logic [IDXW-1:0] hq_head, dq_head;
    logic            hq_nonempty, dq_nonempty;

    logic [POSW-1:0] rd_pos;
    logic            out_fire, drain_done;
    logic            wdata_unused;

    assign wdata_unused = ^{reg_wdata[6:5], reg_wdata[3:0]};

    // lowest-numbered free buffer takes the next packet
    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int b = NBUF - 1; b >= 0; b--) begin
            if (st[b] == B_FREE) begin
                any_free   = 1'b1;
                first_free = IDXW'(b);
            end
        end
    end

    assign wr_buf   = fill_active ? fill_buf : first_free;
    assign wr_len   = len[wr_buf];
    assign rx_ready = fill_active | any_free;
    assign rx_fire  = rx_valid & rx_ready;
    assign pkt_end  = rx_fire & (rx_last | (wr_len == LENW'(DEPTH - 1)));

    assign rearm  = reg_we && (reg_addr == REG_BCL) && hq_nonempty;
    assign skip   = reg_wdata[BCL_SKIP_BIT];
    assign commit = rearm & ~skip;
    assign drop   = rearm & skip;

    assign out_valid  = dq_nonempty;
    assign out_last   = (LENW'(rd_pos) + LENW'(1)) == len[dq_head];
    assign out_fire   = out_valid & out_ready;
    assign drain_done = out_fire & out_last;
    assign pkt_held   = hq_nonempty;

    // packets awaiting a firmware decision, oldest first
    ogate_idxq #(.DEPTH(NBUF), .W(IDXW)) u_held_q (
        .clk(clk), .rst(rst),
        .push0(pkt_end & ~auto_q), .din0(wr_buf),
        .push1(1'b0), .din1('0),
        .pop(rearm),
        .head(hq_head), .nonempty(hq_nonempty)
    );

    // packets queued for the consumer; a commit is older than a same-cycle arrival
    ogate_idxq #(.DEPTH(NBUF), .W(IDXW)) u_drain_q (
        .clk(clk), .rst(rst),
        .push0(commit), .din0(hq_head),
        .push1(pkt_end & auto_q), .din1(wr_buf),
        .pop(drain_done),
        .head(dq_head), .nonempty(dq_nonempty)
    );

    ogate_store #(.NBUF(NBUF), .DEPTH(DEPTH), .DW(DW), .IDXW(IDXW), .POSW(POSW)) u_store (
        .clk(clk),
        .we(rx_fire), .wbuf(wr_buf), .waddr(POSW'(wr_len)), .wdata(rx_data),
        .rbuf(dq_head), .raddr(rd_pos), .rdata(out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q      <= 1'b1;
            fill_active <= 1'b0;
            fill_buf    <= '0;
            rd_pos      <= '0;
        end else begin
            if (reg_we && reg_addr == REG_CFG) auto_q <= reg_wdata[CFG_AUTO_BIT];
            if (rx_fire) begin
                fill_active <= ~pkt_end;
                fill_buf    <= wr_buf;
            end
            if (drain_done)    rd_pos <= '0;
            else if (out_fire) rd_pos <= rd_pos + POSW'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NBUF; b++) begin
            if (rst) begin
                st[b]  <= B_FREE;
                len[b] <= '0;
            end else if (rx_fire && wr_buf == IDXW'(b)) begin
                len[b] <= len[b] + LENW'(1);
                st[b]  <= pkt_end ? (auto_q ? B_DRAIN : B_HELD) : B_FILL;
            end else if (rearm && hq_head == IDXW'(b)) begin
                st[b] <= skip ? B_FREE : B_DRAIN;
                if (skip) len[b] <= '0;
            end else if (drain_done && dq_head == IDXW'(b)) begin
                st[b]  <= B_FREE;
                len[b] <= '0;
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NBUF; gi++) begin : g_buf
            assign occ_flat[gi*LENW +: LENW] = len[gi];

            // R4: a commit queues the buffer and keeps its recorded length
            a_r4_commit_keeps_len: assert property (@(posedge clk) disable iff (rst)
                (commit && hq_head == IDXW'(gi)) |=> (st[gi] == B_DRAIN) && $stable(len[gi]));

            // R5: a skip returns the buffer to the free pool at once
            a_r5_skip_frees: assert property (@(posedge clk) disable iff (rst)
                (drop && hq_head == IDXW'(gi)) |=> (st[gi] == B_FREE) && (len[gi] == '0));

            // R9: only a re-arm aimed at this buffer releases a held packet
            a_r9_held_stays: assert property (@(posedge clk) disable iff (rst)
                (st[gi] == B_HELD && !(rearm && hq_head == IDXW'(gi))) |=> st[gi] == B_HELD);
        end
    endgenerate

    // R3: a manual-mode completion leaves a decision pending
    a_r3_manual_holds: assert property (@(posedge clk) disable iff (rst)
        (pkt_end && !auto_q) |=> pkt_held);

    // R10: a stalled output byte does not move
    a_r10_out_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

endmodule

// File: tb/tb_ogate_commit_gate.sv
`timescale 1ns/1ps
module tb_ogate_commit_gate;
    localparam int NBUF  = 2;
    localparam int DEPTH = 512;
    localparam int DW    = 8;
    localparam int LENW  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
    logic [DW-1:0] rx_data = '0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic out_valid, out_last, out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic pkt_held;
    logic [NBUF*LENW-1:0] occ_flat;

    int n_chk = 0, n_fail = 0;
    bit done_all = 1'b0;
    logic [7:0] got [0:599];
    int got_n;

    always #2 clk = ~clk;

    ogate_commit_gate #(.NBUF(NBUF), .DEPTH(DEPTH), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .pkt_held(pkt_held), .occ_flat(occ_flat)
    );

    function automatic logic [7:0] pat(int seed, int i);
        return 8'(seed * 7 + i * 3 + 1);
    endfunction

    function automatic int occ_sum();
        int s = 0;
        for (int b = 0; b < NBUF; b++) s += int'(occ_flat[b*LENW +: LENW]);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_pkt(input int n, input int seed, input bit no_last);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = pat(seed, i);
            rx_last  = (i == n - 1) && !no_last;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic recv_check(input int n, input int seed, input string req);
        bit fin = 1'b0;
        int bad = 0;
        out_ready = 1'b1;
        got_n = 0;
        for (int c = 0; c < 2000 && !fin; c++) begin
            if (out_valid) begin
                got[got_n] = out_data;
                got_n++;
                if (out_last || got_n >= 600) fin = 1'b1;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(got_n == n, {req, " length"}, got_n, n);
        for (int i = 0; i < got_n && i < n; i++)
            if (got[i] != pat(seed, i)) bad++;
        check(bad == 0, {req, " bytes"}, bad, 0);
    endtask

    task automatic t_reset();
        check(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(pkt_held == 1'b0, "R1 pkt_held", pkt_held, 0);
        check(occ_sum() == 0, "R1 occupancy", occ_sum(), 0);
    endtask

    task automatic t_auto();
        send_pkt(5, 1, 1'b0);
        check(pkt_held == 1'b0, "R2 not held", pkt_held, 0);
        check(out_valid == 1'b1, "R2 forwarded", out_valid, 1);
        recv_check(5, 1, "R2 single");
        send_pkt(3, 2, 1'b0);
        send_pkt(4, 3, 1'b0);
        recv_check(3, 2, "R2 first of two");
        recv_check(4, 3, "R2 second of two");
    endtask

    task automatic t_manual_commit();
        reg_write(2'd0, 8'h00);
        send_pkt(6, 4, 1'b0);
        check(pkt_held == 1'b1, "R3 held", pkt_held, 1);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R3 no output", out_valid, 0);
        check(occ_sum() == 6, "R3 occupancy", occ_sum(), 6);
        reg_write(2'd1, 8'h03);
        check(pkt_held == 1'b1 && out_valid == 1'b0, "R4 high write ignored", out_valid, 0);
        check(occ_sum() == 6, "R4 high write keeps length", occ_sum(), 6);
        reg_write(2'd2, 8'h05);
        check(pkt_held == 1'b0, "R4 released", pkt_held, 0);
        recv_check(6, 4, "R4 committed");
    endtask

    task automatic t_skip();
        send_pkt(4, 5, 1'b0);
        reg_write(2'd2, 8'h80);
        check(pkt_held == 1'b0, "R5 released", pkt_held, 0);
        check(occ_sum() == 0, "R5 buffer freed", occ_sum(), 0);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R5 nothing output", out_valid, 0);
        send_pkt(3, 6, 1'b0);
        reg_write(2'd2, 8'h00);
        recv_check(3, 6, "R5 next packet only");
    endtask

    task automatic t_noheld();
        reg_write(2'd2, 8'h00);
        reg_write(2'd2, 8'h80);
        check(out_valid == 1'b0, "R6 no output", out_valid, 0);
        check(pkt_held == 1'b0, "R6 nothing held", pkt_held, 0);
        check(occ_sum() == 0, "R6 occupancy", occ_sum(), 0);
        send_pkt(2, 7, 1'b0);
        check(pkt_held == 1'b1, "R6 later packet held", pkt_held, 1);
        reg_write(2'd2, 8'h00);
        recv_check(2, 7, "R6 later packet");
    endtask

    task automatic t_order_full();
        send_pkt(3, 8, 1'b0);
        send_pkt(5, 9, 1'b0);
        check(rx_ready == 1'b0, "R8 full pool", rx_ready, 0);
        check(occ_sum() == 8, "R3 two held occupancy", occ_sum(), 8);
        reg_write(2'd2, 8'h00);
        reg_write(2'd2, 8'h00);
        recv_check(3, 8, "R7 oldest first");
        check(rx_ready == 1'b1, "R8 ready again", rx_ready, 1);
        recv_check(5, 9, "R7 second");
        send_pkt(2, 13, 1'b0);
        send_pkt(3, 14, 1'b0);
        reg_write(2'd2, 8'h80);
        reg_write(2'd2, 8'h00);
        recv_check(3, 14, "R7 skip hits oldest");
    endtask

    task automatic t_toggle();
        send_pkt(4, 10, 1'b0);
        reg_write(2'd0, 8'h10);
        repeat (2) @(negedge clk);
        check(pkt_held == 1'b1, "R9 still held", pkt_held, 1);
        check(out_valid == 1'b0, "R9 no release", out_valid, 0);
        send_pkt(2, 11, 1'b0);
        recv_check(2, 11, "R9 direct after enable");
        reg_write(2'd2, 8'h00);
        recv_check(4, 10, "R9 held released by re-arm");
    endtask

    task automatic t_stall();
        logic [7:0] d0;
        logic l0;
        int moved = 0;
        send_pkt(3, 12, 1'b0);
        d0 = out_data;
        l0 = out_last;
        check(d0 == pat(12, 0), "R10 first byte", d0, pat(12, 0));
        repeat (3) begin
            @(negedge clk);
            if (!out_valid || out_data != d0 || out_last != l0) moved++;
        end
        check(moved == 0, "R10 stable while stalled", moved, 0);
        recv_check(3, 12, "R10 after stall");
    endtask

    task automatic t_long();
        send_pkt(DEPTH, 15, 1'b1);
        check(out_valid == 1'b1, "R11 closed at capacity", out_valid, 1);
        recv_check(DEPTH, 15, "R11 full packet");
        check(occ_sum() == 0, "R11 buffer freed", occ_sum(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_auto();
        t_manual_commit();
        t_skip();
        t_noheld();
        t_order_full();
        t_toggle();
        t_stall();
        t_long();
        if (!done_all) begin
            done_all = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_all) begin
            done_all = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule